// File: doc/BRIEF.md
# Descriptor Stream Op Assembler

This block accepts a stream of per-channel push commands and turns each well-formed group of them into one 64-byte transfer descriptor. A group is an optional control-register-write marker, then one generate command, then one or more dimension pushes. The generate command supplies the transfer direction, a 64-bit address, the element size and a completion semaphore number. Each dimension push supplies a source and destination element count and a signed source and destination stride. The last dimension push of a group closes it. The finished descriptor leaves as four 128-bit ring entries on a valid/ready stream, each tagged with its ring slot index in 16-byte units.

Commands that break the grammar, name a channel outside the allowed set, or use an unknown opcode are reported on one-cycle error pulses. A per-transfer descriptor budget (the carve-out size) caps how many descriptors one transfer may produce. The carve-out base is given in descriptors, so every descriptor lands on a 64-byte boundary of the ring.

Top module: `desc_op_assembler`

## Requirements
- R1: After reset, `cmd_ready` is 1, `out_valid` is 0 and all four error outputs are 0.
- R2: Opcodes are 0 = register write, 1 = generate, 2 = dimension push. A group of optional op 0, one op 1 and 1 to 2 op 2 commands, closed by an op 2 with `cmd_last`=1, yields one descriptor sent as four entries, bytes 0-15 first, then 16-31, 32-47 and 48-63, one entry per accepted beat.
- R3: Descriptor layout (little-endian): byte 0 bit 0 = register write present, byte 0 bit 1 = direction (0 read, 1 write), byte 1 = channel of the generate, bytes 4-5 = element size, byte 13 = semaphore number, byte 14 = semaphore increment (always 1). A read puts the address at bytes 16-23, a write at bytes 40-47; the other address field is zero. All other bytes not named in R3 or R4 are zero.
- R4: Byte 2 holds the number of dimension pushes. Dimension 0 occupies bytes 24-35 and dimension 1 bytes 48-59, each as source count (2 bytes), destination count (2), source stride (4), destination stride (4); an unpushed dimension is zero.
- R5: With `HAS_REGWR`=0, op 0 raises `err_illegal`, is ignored, and byte 0 bit 0 is never set.
- R6: Op 3 raises `err_illegal` and leaves the assembly state untouched.
- R7: A command whose channel index is not a set bit of `CHAN_MASK` (default 0x00F5) raises `err_chan` and is ignored.
- R8: A dimension push before a generate, a generate or register write after a generate, or a third dimension push raises `err_seq` and discards the partial descriptor.
- R9: While a descriptor is being sent, `cmd_ready` is 0; with `out_ready` low, `out_valid`, `out_data` and `out_slot` hold.
- R10: `out_slot` = (`CARVE_BASE` + k) * 4 + beat, where k counts descriptors already sent in the current transfer; a descriptor closed with `cmd_xfer_end`=1 ends the transfer and k returns to 0.
- R11: When `CARVE_CAP` descriptors have been sent in a transfer, closing another raises `err_cap`, sends nothing and ends the transfer.
- R12: Each error output pulses high for exactly the one cycle after the offending command is accepted, and at most one error output is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 2 | Opcode: 0 register write, 1 generate, 2 dimension push |
| cmd_chan | input | 4 | Target channel index |
| cmd_dir | input | 1 | Generate direction: 0 read, 1 write |
| cmd_addr | input | 64 | Generate address |
| cmd_esize | input | 16 | Generate element size in bytes |
| cmd_sem | input | 8 | Generate semaphore number |
| cmd_num_src | input | 16 | Dimension source count |
| cmd_num_dst | input | 16 | Dimension destination count |
| cmd_step_src | input | 32 | Dimension source stride, signed |
| cmd_step_dst | input | 32 | Dimension destination stride, signed |
| cmd_last | input | 1 | This dimension push closes the descriptor |
| cmd_xfer_end | input | 1 | The closed descriptor ends the transfer |
| out_valid | output | 1 | Ring entry present |
| out_ready | input | 1 | Ring entry taken |
| out_data | output | 128 | Ring entry, 16 bytes |
| out_slot | output | 16 | Ring slot index in 16-byte units |
| out_chan | output | 4 | Channel of the descriptor being sent |
| err_seq | output | 1 | Grammar error pulse |
| err_illegal | output | 1 | Unknown or disabled opcode pulse |
| err_chan | output | 1 | Disallowed channel pulse |
| err_cap | output | 1 | Carve-out budget exceeded pulse |

## Verification
A corrupted grammar state shows up on the very next command: an extra or missing `err_seq` pulse one cycle after acceptance, or a descriptor that is sent when it should have been dropped. A wrong field register or dimension slot shows up in the first ring entry that carries that byte range, at most four accepted beats after the closing command. A drifting transfer counter shows up as a wrong `out_slot` on the next descriptor's first beat or as a missing or early `err_cap`, and a wrong beat counter breaks the lowest-first entry order within the same descriptor.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  localparam int ENTRY_W = 128;
  localparam int BEATS   = 4;
  localparam int WORD_W  = ENTRY_W * BEATS;
  localparam int BEAT_W  = $clog2(BEATS);
  localparam int DIMS    = 2;
  localparam int DIM_W   = $clog2(DIMS + 1);
  localparam int CH_W    = 4;
  localparam int ADDR_W  = 64;
  localparam int ESZ_W   = 16;
  localparam int SEM_W   = 8;
  localparam int NUM_W   = 16;
  localparam int STEP_W  = 32;
  localparam int DIMREC_W = 2 * NUM_W + 2 * STEP_W;

  // byte offsets inside the 64-byte descriptor
  localparam int B_FLAGS = 0;
  localparam int B_CHAN  = 1;
  localparam int B_NDIM  = 2;
  localparam int B_ESZ   = 4;
  localparam int B_SEM   = 13;
  localparam int B_SINC  = 14;
  localparam int B_SRCA  = 16;
  localparam int B_DSTA  = 40;

  typedef enum logic [1:0] {
    OP_REGWR = 2'd0,
    OP_GEN   = 2'd1,
    OP_DIM   = 2'd2,
    OP_BAD   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RW, S_GEN, S_DIM, S_EMIT
  } st_e;

  typedef struct packed {
    logic [STEP_W-1:0] sd;
    logic [STEP_W-1:0] ss;
    logic [NUM_W-1:0]  nd;
    logic [NUM_W-1:0]  ns;
  } dim_t;

  function automatic int dim_ofs(input int i);
    return (i == 0) ? 24 : 48;
  endfunction
endpackage

// File: rtl/dsa_seq.sv
module dsa_seq import dsa_pkg::*; #(
  parameter bit          HAS_REGWR = 1'b1,
  parameter logic [15:0] CHAN_MASK = 16'h00F5,
  parameter int          CAP       = 4,
  localparam int         CNT_W     = $clog2(CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [CH_W-1:0]  cmd_chan,
  input  logic             cmd_last,
  input  logic             cmd_xend,
  input  logic             emit_done,
  output logic             cmd_ready,
  output logic             emitting,
  output logic             take_rw,
  output logic             take_gen,
  output logic             gen_rw,
  output logic             take_dim,
  output logic [DIM_W-1:0] ndim,
  output logic [CNT_W-1:0] dcnt,
  output logic             err_seq,
  output logic             err_illegal,
  output logic             err_chan,
  output logic             err_cap
);
  st_e              st, st_n;
  logic [DIM_W-1:0] ndim_n;
  logic [CNT_W-1:0] dcnt_n;
  logic             xend_q, xend_n;
  logic             e_seq, e_ill, e_ch, e_cap;
  logic             acc, chan_ok;

  assign emitting  = (st == S_EMIT);
  assign cmd_ready = !emitting;
  assign acc       = cmd_valid && cmd_ready;
  assign chan_ok   = CHAN_MASK[cmd_chan];
  assign gen_rw    = (st == S_RW);

  always_comb begin
    st_n = st; ndim_n = ndim; dcnt_n = dcnt; xend_n = xend_q;
    take_rw = 1'b0; take_gen = 1'b0; take_dim = 1'b0;
    e_seq = 1'b0; e_ill = 1'b0; e_ch = 1'b0; e_cap = 1'b0;
    if (emitting) begin
      if (emit_done) begin
        st_n   = S_IDLE;
        ndim_n = '0;
        dcnt_n = xend_q ? '0 : CNT_W'(dcnt + 1'b1);
      end
    end else if (acc) begin
      if (op_e'(cmd_op) == OP_BAD || (op_e'(cmd_op) == OP_REGWR && !HAS_REGWR)) begin
        e_ill = 1'b1;
      end else if (!chan_ok) begin
        e_ch = 1'b1;
      end else begin
        case (op_e'(cmd_op))
          OP_REGWR: begin
            if (st == S_IDLE) begin
              take_rw = 1'b1; st_n = S_RW;
            end else begin
              e_seq = 1'b1; st_n = S_IDLE; ndim_n = '0;
            end
          end
          OP_GEN: begin
            if (st == S_IDLE || st == S_RW) begin
              take_gen = 1'b1; st_n = S_GEN;
            end else begin
              e_seq = 1'b1; st_n = S_IDLE; ndim_n = '0;
            end
          end
          default: begin
            if ((st == S_GEN || st == S_DIM) && ndim < DIM_W'(DIMS)) begin
              take_dim = 1'b1;
              ndim_n   = DIM_W'(ndim + 1'b1);
              if (!cmd_last) begin
                st_n = S_DIM;
              end else if (dcnt == CNT_W'(CAP)) begin
                e_cap = 1'b1; st_n = S_IDLE; ndim_n = '0; dcnt_n = '0;
              end else begin
                st_n = S_EMIT; xend_n = cmd_xend;
              end
            end else begin
              e_seq = 1'b1; st_n = S_IDLE; ndim_n = '0;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ndim <= '0; dcnt <= '0; xend_q <= 1'b0;
      err_seq <= 1'b0; err_illegal <= 1'b0; err_chan <= 1'b0; err_cap <= 1'b0;
    end else begin
      st <= st_n; ndim <= ndim_n; dcnt <= dcnt_n; xend_q <= xend_n;
      err_seq <= e_seq; err_illegal <= e_ill; err_chan <= e_ch; err_cap <= e_cap;
    end
  end

  p_cap_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= CNT_W'(CAP));
  p_dim_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ndim <= DIM_W'(DIMS));
  p_one_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_seq, err_illegal, err_chan, err_cap}));
  p_bad_op_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && op_e'(cmd_op) == OP_BAD) |=> (err_illegal && st == $past(st)));
endmodule

// File: rtl/dsa_store.sv
module dsa_store import dsa_pkg::*; #(
  parameter bit HAS_REGWR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_rw,
  input  logic              take_gen,
  input  logic              gen_rw,
  input  logic              take_dim,
  input  logic [DIM_W-1:0]  ndim,
  input  logic [CH_W-1:0]   cmd_chan,
  input  logic              cmd_dir,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ESZ_W-1:0]  cmd_esize,
  input  logic [SEM_W-1:0]  cmd_sem,
  input  logic [NUM_W-1:0]  cmd_num_src,
  input  logic [NUM_W-1:0]  cmd_num_dst,
  input  logic [STEP_W-1:0] cmd_step_src,
  input  logic [STEP_W-1:0] cmd_step_dst,
  output logic [WORD_W-1:0] word,
  output logic [CH_W-1:0]   chan
);
  logic              rw;
  logic              dir_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ESZ_W-1:0]  esz_q;
  logic [SEM_W-1:0]  sem_q;
  dim_t              dim_q [DIMS];

  generate
    if (HAS_REGWR) begin : g_rw
      logic rw_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rw_q <= 1'b0;
        else if (take_rw)  rw_q <= 1'b1;
        else if (take_gen) rw_q <= gen_rw;
      end
      assign rw = rw_q;
    end else begin : g_no_rw
      assign rw = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan <= '0; dir_q <= 1'b0; addr_q <= '0; esz_q <= '0; sem_q <= '0;
    end else if (take_gen) begin
      chan <= cmd_chan; dir_q <= cmd_dir; addr_q <= cmd_addr;
      esz_q <= cmd_esize; sem_q <= cmd_sem;
    end
  end

  for (genvar i = 0; i < DIMS; i++) begin : g_dim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dim_q[i] <= '0;
      end else if (take_gen) begin
        dim_q[i] <= '0;
      end else if (take_dim && ndim == DIM_W'(i)) begin
        dim_q[i] <= '{sd: cmd_step_dst, ss: cmd_step_src, nd: cmd_num_dst, ns: cmd_num_src};
      end
    end
  end

  always_comb begin
    word = '0;
    word[B_FLAGS*8 +: 8]  = {6'b0, dir_q, rw};
    word[B_CHAN*8 +: 8]   = 8'(chan);
    word[B_NDIM*8 +: 8]   = 8'(ndim);
    word[B_ESZ*8 +: ESZ_W] = esz_q;
    word[B_SEM*8 +: SEM_W] = sem_q;
    word[B_SINC*8 +: 8]   = 8'd1;
    if (dir_q) word[B_DSTA*8 +: ADDR_W] = addr_q;
    else       word[B_SRCA*8 +: ADDR_W] = addr_q;
    for (int i = 0; i < DIMS; i++) begin
      word[dim_ofs(i)*8 +: DIMREC_W] = dim_q[i];
    end
  end
endmodule

// File: rtl/dsa_emit.sv
module dsa_emit import dsa_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              out_ready,
  input  logic [WORD_W-1:0] word,
  output logic              out_valid,
  output logic [ENTRY_W-1:0] out_data,
  output logic [BEAT_W-1:0] beat,
  output logic              done
);
  logic              fire;
  logic [BEAT_W-1:0] beat_n;

  assign out_valid = go;
  assign fire      = out_valid && out_ready;
  assign done      = fire && (beat == BEAT_W'(BEATS - 1));
  assign out_data  = word[beat*ENTRY_W +: ENTRY_W];

  always_comb begin
    beat_n = beat;
    if (done)      beat_n = '0;
    else if (fire) beat_n = BEAT_W'(beat + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat <= '0;
    else        beat <= beat_n;
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(beat)));
  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && beat != BEAT_W'(BEATS - 1)) |=>
      (out_valid && beat == BEAT_W'($past(beat) + 1'b1)));
endmodule

// File: rtl/desc_op_assembler.sv
module desc_op_assembler import dsa_pkg::*; #(
  parameter bit          HAS_REGWR  = 1'b1,
  parameter logic [15:0] CHAN_MASK  = 16'h00F5,
  parameter int          CARVE_BASE = 3,
  parameter int          CARVE_CAP  = 4,
  parameter int          SLOT_W     = 16,
  localparam int         CNT_W      = $clog2(CARVE_CAP + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [CH_W-1:0]    cmd_chan,
  input  logic               cmd_dir,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [ESZ_W-1:0]   cmd_esize,
  input  logic [SEM_W-1:0]   cmd_sem,
  input  logic [NUM_W-1:0]   cmd_num_src,
  input  logic [NUM_W-1:0]   cmd_num_dst,
  input  logic [STEP_W-1:0]  cmd_step_src,
  input  logic [STEP_W-1:0]  cmd_step_dst,
  input  logic               cmd_last,
  input  logic               cmd_xfer_end,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ENTRY_W-1:0] out_data,
  output logic [SLOT_W-1:0]  out_slot,
  output logic [CH_W-1:0]    out_chan,
  output logic               err_seq,
  output logic               err_illegal,
  output logic               err_chan,
  output logic               err_cap
);
  logic [1:0]         rst_sync;
  logic               rst_i;
  logic               emitting, take_rw, take_gen, gen_rw, take_dim, done;
  logic [DIM_W-1:0]   ndim;
  logic [CNT_W-1:0]   dcnt;
  logic [BEAT_W-1:0]  beat;
  logic [WORD_W-1:0]  word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  dsa_seq #(.HAS_REGWR(HAS_REGWR), .CHAN_MASK(CHAN_MASK), .CAP(CARVE_CAP)) u_seq (
    .clk(clk), .rst_n(rst_i), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_chan(cmd_chan), .cmd_last(cmd_last), .cmd_xend(cmd_xfer_end),
    .emit_done(done), .cmd_ready(cmd_ready), .emitting(emitting),
    .take_rw(take_rw), .take_gen(take_gen), .gen_rw(gen_rw), .take_dim(take_dim),
    .ndim(ndim), .dcnt(dcnt), .err_seq(err_seq), .err_illegal(err_illegal),
    .err_chan(err_chan), .err_cap(err_cap));

  dsa_store #(.HAS_REGWR(HAS_REGWR)) u_store (
    .clk(clk), .rst_n(rst_i), .take_rw(take_rw), .take_gen(take_gen),
    .gen_rw(gen_rw), .take_dim(take_dim), .ndim(ndim), .cmd_chan(cmd_chan),
    .cmd_dir(cmd_dir), .cmd_addr(cmd_addr), .cmd_esize(cmd_esize), .cmd_sem(cmd_sem),
    .cmd_num_src(cmd_num_src), .cmd_num_dst(cmd_num_dst),
    .cmd_step_src(cmd_step_src), .cmd_step_dst(cmd_step_dst),
    .word(word), .chan(out_chan));

  dsa_emit u_emit (
    .clk(clk), .rst_n(rst_i), .go(emitting), .out_ready(out_ready), .word(word),
    .out_valid(out_valid), .out_data(out_data), .beat(beat), .done(done));

  assign out_slot = SLOT_W'(CARVE_BASE * BEATS) + SLOT_W'({dcnt, 2'b00}) + SLOT_W'(beat);

  p_chan_allowed_r7: assert property (@(posedge clk) disable iff (!rst_i)
    out_valid |-> CHAN_MASK[out_chan]);
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid && !out_ready) |=> (out_valid && !cmd_ready && $stable(out_slot)));
endmodule

// File: tb/desc_op_assembler_test.sv
`timescale 1ns/1ps
module desc_op_assembler_test;
  typedef struct packed {
    logic        rw;
    logic        dir;
    logic [3:0]  chan;
    logic [63:0] addr;
    logic [15:0] esz;
    logic [7:0]  sem;
    logic [1:0]  nd;
    logic [15:0] ns0, nd0;
    logic [31:0] ss0, sd0;
    logic [15:0] ns1, nd1;
    logic [31:0] ss1, sd1;
    logic        xend;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{1'b1, 1'b0, 4'd0, 64'h0000_0012_3456_7890, 16'd4, 8'd3, 2'd2,
      16'd8, 16'd8, 32'd1, 32'd1, 16'd3, 16'd3, 32'd8, 32'd8, 1'b0},
    '{1'b0, 1'b1, 4'd5, 64'hFFFF_8000_0000_1000, 16'd2, 8'hA5, 2'd1,
      16'h0100, 16'h0040, 32'hFFFF_FFFC, 32'd4, 16'd0, 16'd0, 32'd0, 32'd0, 1'b1},
    '{1'b1, 1'b1, 4'd7, 64'h0123_4567_89AB_CDEF, 16'd8, 8'd0, 2'd2,
      16'hFFFF, 16'd1, 32'h8000_0000, 32'h7FFF_FFFF, 16'd2, 16'd7, 32'hFFFF_FF00, 32'd16, 1'b0},
    '{1'b0, 1'b0, 4'd2, 64'h0000_0000_DEAD_0040, 16'd1, 8'd63, 2'd1,
      16'd16, 16'd16, 32'd2, 32'hFFFF_FFFE, 16'd0, 16'd0, 32'd0, 32'd0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_dir = 1'b0, cmd_last = 1'b0, cmd_xfer_end = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [3:0]  cmd_chan = 4'd0;
  logic [63:0] cmd_addr = '0;
  logic [15:0] cmd_esize = '0, cmd_num_src = '0, cmd_num_dst = '0;
  logic [7:0]  cmd_sem = '0;
  logic [31:0] cmd_step_src = '0, cmd_step_dst = '0;
  logic out_ready = 1'b1;
  logic cmd_ready, out_valid, err_seq, err_illegal, err_chan, err_cap;
  logic [127:0] out_data;
  logic [15:0]  out_slot;
  logic [3:0]   out_chan;
  logic n_ready, n_valid, n_es, n_ei, n_ec, n_ecap;
  logic [127:0] n_data;
  logic [15:0]  n_slot;
  logic [3:0]   n_chan;

  int nchk = 0, nfail = 0, exp_k = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  desc_op_assembler uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_dir(cmd_dir), .cmd_addr(cmd_addr),
    .cmd_esize(cmd_esize), .cmd_sem(cmd_sem), .cmd_num_src(cmd_num_src),
    .cmd_num_dst(cmd_num_dst), .cmd_step_src(cmd_step_src), .cmd_step_dst(cmd_step_dst),
    .cmd_last(cmd_last), .cmd_xfer_end(cmd_xfer_end), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_slot(out_slot), .out_chan(out_chan),
    .err_seq(err_seq), .err_illegal(err_illegal), .err_chan(err_chan), .err_cap(err_cap));

  desc_op_assembler #(.HAS_REGWR(1'b0)) uut_norw (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(n_ready),
    .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_dir(cmd_dir), .cmd_addr(cmd_addr),
    .cmd_esize(cmd_esize), .cmd_sem(cmd_sem), .cmd_num_src(cmd_num_src),
    .cmd_num_dst(cmd_num_dst), .cmd_step_src(cmd_step_src), .cmd_step_dst(cmd_step_dst),
    .cmd_last(cmd_last), .cmd_xfer_end(cmd_xfer_end), .out_valid(n_valid),
    .out_ready(out_ready), .out_data(n_data), .out_slot(n_slot), .out_chan(n_chan),
    .err_seq(n_es), .err_illegal(n_ei), .err_chan(n_ec), .err_cap(n_ecap));

  function automatic logic [511:0] mk(input vec_t v);
    logic [511:0] w = '0;
    w[0] = v.rw; w[1] = v.dir;
    w[11:8] = v.chan;
    w[23:16] = {6'b0, v.nd};
    w[47:32] = v.esz;
    w[111:104] = v.sem;
    w[119:112] = 8'd1;
    if (v.dir) w[383:320] = v.addr;
    else       w[191:128] = v.addr;
    w[287:192] = {v.sd0, v.ss0, v.nd0, v.ns0};
    if (v.nd == 2'd2) w[479:384] = {v.sd1, v.ss1, v.nd1, v.ns1};
    return w;
  endfunction

  task automatic check(input string tag, input logic [159:0] got, input logic [159:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [3:0] ch, input vec_t v,
                     input bit sel1, input bit last, input bit xend);
    @(negedge clk);
    cmd_op = op; cmd_chan = ch; cmd_dir = v.dir; cmd_addr = v.addr;
    cmd_esize = v.esz; cmd_sem = v.sem; cmd_last = last; cmd_xfer_end = xend;
    cmd_num_src  = sel1 ? v.ns1 : v.ns0; cmd_num_dst  = sel1 ? v.nd1 : v.nd0;
    cmd_step_src = sel1 ? v.ss1 : v.ss0; cmd_step_dst = sel1 ? v.sd1 : v.sd0;
    cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic collect(input vec_t v, input string tag);
    logic [511:0] w = mk(v);
    for (int b = 0; b < 4; b++) begin
      check(tag, {11'b0, out_valid, out_chan, out_slot, out_data},
            {11'b0, 1'b1, v.chan, 16'((3 + exp_k) * 4 + b), w[b*128 +: 128]});
      @(posedge clk); #1;
    end
    exp_k = v.xend ? 0 : exp_k + 1;
  endtask

  task automatic open_desc(input vec_t v);
    if (v.rw) cmd(2'd0, v.chan, v, 1'b0, 1'b0, 1'b0);
    cmd(2'd1, v.chan, v, 1'b0, 1'b0, 1'b0);
    cmd(2'd2, v.chan, v, 1'b0, v.nd == 2'd1, v.xend);
    if (v.nd == 2'd2) cmd(2'd2, v.chan, v, 1'b1, 1'b1, v.xend);
  endtask

  function automatic logic [159:0] errs();
    return {156'b0, err_seq, err_illegal, err_chan, err_cap};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      nfail++;
      $display("FAIL watchdog (all requirements): actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset", {154'b0, cmd_ready, out_valid, err_seq, err_illegal, err_chan, err_cap},
          {154'b0, 6'b100000});

    // R2 R3 R4 R10 table walk
    for (int i = 0; i < 4; i++) begin
      open_desc(VEC[i]);
      collect(VEC[i], "R2/R3/R4/R10 table");
    end

    // R8 dim before generate, then R12 single-cycle pulse
    cmd(2'd2, 4'd0, VEC[3], 1'b0, 1'b1, 1'b1);
    check("R8 dim before gen", errs(), 160'b1000);
    @(posedge clk); #1;
    check("R12 pulse ends", errs(), 160'b0);

    // R8 generate after generate, partial discarded
    cmd(2'd1, 4'd0, VEC[0], 1'b0, 1'b0, 1'b0);
    cmd(2'd1, 4'd0, VEC[0], 1'b0, 1'b0, 1'b0);
    check("R8 gen after gen", errs(), 160'b1000);
    cmd(2'd2, 4'd0, VEC[0], 1'b0, 1'b1, 1'b1);
    check("R8 discarded, dim now early", errs(), 160'b1000);

    // R8 third dimension push
    v = VEC[2]; v.xend = 1'b1;
    cmd(2'd1, v.chan, v, 1'b0, 1'b0, 1'b0);
    cmd(2'd2, v.chan, v, 1'b0, 1'b0, 1'b0);
    cmd(2'd2, v.chan, v, 1'b1, 1'b0, 1'b0);
    cmd(2'd2, v.chan, v, 1'b1, 1'b1, 1'b1);
    check("R8 third dim", errs(), 160'b1000);
    check("R8 nothing sent", {159'b0, out_valid}, 160'b0);

    // R6 bad opcode ignored mid-descriptor, R7 disallowed channel ignored
    v = VEC[3];
    cmd(2'd1, v.chan, v, 1'b0, 1'b0, 1'b0);
    cmd(2'd3, v.chan, v, 1'b0, 1'b1, 1'b1);
    check("R6 bad opcode", errs(), 160'b0100);
    cmd(2'd2, 4'd1, v, 1'b0, 1'b1, 1'b1);
    check("R7 masked channel", errs(), 160'b0010);
    cmd(2'd2, v.chan, v, 1'b0, 1'b1, 1'b1);
    collect(v, "R6/R7 state kept");

    // R11 carve-out budget, R10 count restart
    v = VEC[0]; v.xend = 1'b0;
    for (int i = 0; i < 4; i++) begin
      open_desc(v);
      collect(v, "R10 slots in transfer");
    end
    open_desc(v);
    check("R11 cap error", {155'b0, out_valid, err_seq, err_illegal, err_chan, err_cap},
          {155'b0, 5'b00001});
    exp_k = 0;
    open_desc(VEC[3]);
    collect(VEC[3], "R11 transfer restarted");

    // R9 backpressure
    out_ready = 1'b0;
    open_desc(VEC[1]);
    for (int i = 0; i < 3; i++) begin
      check("R9 hold", {14'b0, out_valid, cmd_ready, out_slot, out_data},
            {14'b0, 1'b1, 1'b0, 16'd12, mk(VEC[1])[127:0]});
      @(posedge clk); #1;
    end
    out_ready = 1'b1;
    collect(VEC[1], "R9 release");

    // R5 register write disabled by parameter
    v = VEC[2]; v.xend = 1'b1;
    cmd(2'd0, v.chan, v, 1'b0, 1'b0, 1'b0);
    check("R5 illegal regwr", {156'b0, n_es, n_ei, n_ec, n_ecap}, 160'b0100);
    cmd(2'd1, v.chan, v, 1'b0, 1'b0, 1'b0);
    cmd(2'd2, v.chan, v, 1'b0, 1'b0, 1'b0);
    cmd(2'd2, v.chan, v, 1'b1, 1'b1, 1'b1);
    check("R5 flag bit", {158'b0, n_valid, n_data[0]}, 160'b10);
    collect(v, "R5 enabled instance");

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule